// File: doc/BRIEF.md
# Full-Scan Test Sequencer

This block runs a complete manufacturing test on one mux-D scan chain of `CHAIN_LEN` flip-flops. It drives the chain's test-control line, its serial input and the primary-input vector, and it watches the serial output and the primary outputs. A run has two parts. The first is a chain-integrity flush that checks the chain as a plain shift register. The second applies `NUM_VEC` combinational vectors, each loaded serially, captured once, and unloaded while the following vector loads.

The vectors sit in a small internal memory that is written through a simple port while the sequencer is idle. Each entry holds four fields: the present-state bits to scan in, the primary-input value, the expected primary outputs and the expected next state. Every mismatch sets a sticky fail flag and adds one to a saturating counter of failing cycles. A free-running cycle count lets the surrounding logic confirm the exact length of the test.

Top module: `scan_test_sequencer`

## Requirements
- R1: After reset, `scan_tc`, `scan_si`, `scan_pi`, `busy`, `done`, `fail`, `fail_cnt` and `cycle_cnt` are all zero.
- R2: A run starts with `CHAIN_LEN+4` shift cycles (`scan_tc`=0). In flush cycle j, `scan_si` equals bit 1 of j, which gives the pattern 0,0,1,1 repeated.
- R3: During flush cycles j ≥ `CHAIN_LEN`, `scan_so` is compared with the flush bit sent in cycle j−`CHAIN_LEN`. A chain defect is therefore reported even when every later comparison would agree.
- R4: Each vector is loaded by `CHAIN_LEN` shift cycles, most significant state bit first, so that state bit i ends in chain stage i. The load is followed by exactly one cycle with `scan_tc`=1, in which `scan_pi` carries that vector's input value. Outside capture cycles, `scan_pi` is 0.
- R5: The first capture falls in run cycle 2·`CHAIN_LEN`+4, counting from 0. Every later capture comes `CHAIN_LEN`+1 cycles after the one before it.
- R6: After the last capture, the sequencer runs `CHAIN_LEN` unload shift cycles with `scan_si` held at 0.
- R7: When `done` is high, `cycle_cnt` equals (`NUM_VEC`+2)·`CHAIN_LEN` + `NUM_VEC` + 4.
- R8: A run in which every observed value matches ends with `fail`=0 and `fail_cnt`=0. A `start` accepted while idle clears both flags from the previous run.
- R9: In each capture cycle, `po_obs` is compared with the vector's expected outputs. A mismatch sets `fail` and adds one to `fail_cnt`.
- R10: The response of vector k is compared bit by bit at `scan_so` while vector k+1 loads, or during the final unload for the last vector. Stage `CHAIN_LEN`−1−j is compared in shift cycle j, and each differing bit adds one to `fail_cnt`.
- R11: `done` is high for exactly one cycle, in the cycle right after the last unload shift. `busy` is low in that cycle.
- R12: `start` is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| vec_we | input | 1 | Vector memory write enable |
| vec_addr | input | VEC_AW | Vector memory write address |
| vec_state | input | CHAIN_LEN | Present-state bits to scan in |
| vec_pi | input | PI_W | Primary-input value for capture |
| vec_exp_po | input | PO_W | Expected primary outputs |
| vec_exp_ns | input | CHAIN_LEN | Expected captured next state |
| scan_tc | output | 1 | Test control: 0 = shift, 1 = functional capture |
| scan_si | output | 1 | Serial scan input |
| scan_pi | output | PI_W | Primary-input vector |
| scan_so | input | 1 | Serial scan output of the chain |
| po_obs | input | PO_W | Primary outputs of the logic under test |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_cnt | output | FAIL_W | Saturating count of failing cycles |
| cycle_cnt | output | CYC_W | Cycles elapsed in the current run |

## Verification
The assertions rely on a few conditions at the block's edge. `CHAIN_LEN` must be at least 2. The vector memory must not be rewritten during a run. `scan_so` and `po_obs` must come from a chain that samples the sequencer's registered drive on the same clock edge. The bench meets these conditions by using a behavioural four-stage chain whose stages update only on the rising edge. It writes the memory only while `busy` is low. It pulses `start` at falling edges, and the one extra pulse it sends mid-run falls while the sequencer is busy.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FLUSH,
    PH_SHIFT,
    PH_CAP,
    PH_UNLOAD,
    PH_DONE
  } phase_t;

  function automatic logic is_active(input phase_t p);
    return (p == PH_FLUSH) || (p == PH_SHIFT) || (p == PH_CAP) || (p == PH_UNLOAD);
  endfunction

endpackage

// File: rtl/scan_vec_store.sv
module scan_vec_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int W     = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int N     = 4,
  parameter int NV    = 4,
  parameter int PI_W  = 4,
  parameter int PO_W  = 4,
  parameter int VAW   = 2,
  parameter int CYC_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [2*N+PI_W+PO_W-1:0] rd_data,
  output logic [VAW-1:0]         rd_addr,
  output logic                   scan_tc,
  output logic                   scan_si,
  output logic [PI_W-1:0]        scan_pi,
  output logic                   busy,
  output logic                   done,
  output logic [CYC_W-1:0]       cycle_cnt,
  output logic                   run_clr,
  output logic                   so_chk_en,
  output logic                   so_exp,
  output logic                   po_chk_en,
  output logic [PO_W-1:0]        po_exp
);

  localparam int NS_LO = 0;
  localparam int PO_LO = N;
  localparam int PI_LO = N + PO_W;
  localparam int ST_LO = N + PO_W + PI_W;
  localparam int REC_W = 2*N + PI_W + PO_W;
  localparam int CW    = $clog2(N + 5);
  localparam int SELW  = $clog2(N);
  localparam logic [CW-1:0]   FL_LAST = CW'(N + 3);
  localparam logic [CW-1:0]   SH_LAST = CW'(N - 1);
  localparam logic [CW-1:0]   CW_N    = CW'(N);
  localparam logic [SELW-1:0] TOP_SEL = SELW'(N - 1);
  localparam logic [VAW-1:0]  V_LAST  = VAW'(NV - 1);

  phase_t         ph, ph_n;
  logic [CW-1:0]  cnt, cnt_n;
  logic [VAW-1:0] vidx, vidx_n;
  logic [REC_W-1:0] cur;
  logic [N-1:0]   prev_ns;
  logic [REC_W-1:0] ld_vec;
  logic [N-1:0]   ld_state;
  logic [SELW-1:0] sel_n, sel;
  logic [CW-1:0]  fl_off;
  logic           si_n;

  // next phase and counters
  always_comb begin
    ph_n   = ph;
    cnt_n  = cnt;
    vidx_n = vidx;
    unique case (ph)
      PH_IDLE: if (start) begin
        ph_n = PH_FLUSH; cnt_n = '0; vidx_n = '0;
      end
      PH_FLUSH: if (cnt == FL_LAST) begin
        ph_n = PH_SHIFT; cnt_n = '0;
      end else cnt_n = cnt + 1'b1;
      PH_SHIFT: if (cnt == SH_LAST) begin
        ph_n = PH_CAP; cnt_n = '0;
      end else cnt_n = cnt + 1'b1;
      PH_CAP: if (vidx == V_LAST) begin
        ph_n = PH_UNLOAD; cnt_n = '0;
      end else begin
        ph_n = PH_SHIFT; cnt_n = '0; vidx_n = vidx + 1'b1;
      end
      PH_UNLOAD: if (cnt == SH_LAST) begin
        ph_n = PH_DONE; cnt_n = '0;
      end else cnt_n = cnt + 1'b1;
      default: ph_n = PH_IDLE;
    endcase
  end

  // prefetch address: entry 0 during flush, next vector otherwise
  always_comb begin
    if (ph == PH_IDLE || ph == PH_FLUSH || vidx == V_LAST) rd_addr = '0;
    else rd_addr = vidx + 1'b1;
  end

  // serial data for the next cycle
  assign ld_vec   = (ph == PH_SHIFT) ? cur : rd_data;
  assign ld_state = ld_vec[ST_LO +: N];
  assign sel_n    = TOP_SEL - cnt_n[SELW-1:0];

  always_comb begin
    unique case (ph_n)
      PH_FLUSH: si_n = cnt_n[1];
      PH_SHIFT: si_n = ld_state[sel_n];
      default:  si_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      vidx      <= '0;
      cur       <= '0;
      prev_ns   <= '0;
      scan_tc   <= 1'b0;
      scan_si   <= 1'b0;
      scan_pi   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      cycle_cnt <= '0;
    end else begin
      ph   <= ph_n;
      cnt  <= cnt_n;
      vidx <= vidx_n;
      if ((ph == PH_FLUSH && cnt == FL_LAST) || (ph == PH_CAP && vidx != V_LAST))
        cur <= rd_data;
      if (ph == PH_CAP)
        prev_ns <= cur[NS_LO +: N];
      scan_tc <= (ph_n == PH_CAP);
      scan_si <= si_n;
      scan_pi <= (ph_n == PH_CAP) ? cur[PI_LO +: PI_W] : '0;
      busy    <= is_active(ph_n);
      done    <= (ph_n == PH_DONE);
      if (ph == PH_IDLE && start) cycle_cnt <= '0;
      else if (is_active(ph))     cycle_cnt <= cycle_cnt + 1'b1;
    end
  end

  // comparison requests for the cycle now in progress
  assign run_clr   = (ph == PH_IDLE) && start;
  assign sel       = TOP_SEL - cnt[SELW-1:0];
  assign fl_off    = cnt - CW_N;
  assign so_chk_en = (ph == PH_FLUSH && cnt >= CW_N) ||
                     (ph == PH_SHIFT && vidx != '0) ||
                     (ph == PH_UNLOAD);
  assign so_exp    = (ph == PH_FLUSH) ? fl_off[1] : prev_ns[sel];
  assign po_chk_en = (ph == PH_CAP);
  assign po_exp    = cur[PO_LO +: PO_W];

  // capture is a single cycle between shifts
  p_capture_single_r4: assert property (@(posedge clk) disable iff (rst)
    scan_tc |=> !scan_tc);

  // capture only happens with the scan path between loads
  p_capture_phase_r5: assert property (@(posedge clk) disable iff (rst)
    scan_tc |-> (ph == PH_CAP));

  // unload shifts carry the fill value
  p_unload_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_UNLOAD) |-> !scan_si);

  // running count advances once per active cycle
  p_cycle_step_r7: assert property (@(posedge clk) disable iff (rst)
    is_active(ph) |=> (cycle_cnt == $past(cycle_cnt) + 1'b1));

  // end pulse lasts one cycle and is not overlapped by busy
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // a start during a run leaves the phase sequence alone
  p_start_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (start && ph == PH_SHIFT && cnt != SH_LAST) |=> (ph == PH_SHIFT));

endmodule

// File: rtl/scan_resp_check.sv
module scan_resp_check #(
  parameter int PO_W   = 4,
  parameter int FAIL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              so_en,
  input  logic              so_exp,
  input  logic              so_obs,
  input  logic              po_en,
  input  logic [PO_W-1:0]   po_exp,
  input  logic [PO_W-1:0]   po_obs,
  output logic              fail,
  output logic [FAIL_W-1:0] fail_cnt
);

  logic mism;

  assign mism = (so_en && (so_obs != so_exp)) || (po_en && (po_obs != po_exp));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail     <= 1'b0;
      fail_cnt <= '0;
    end else if (mism) begin
      fail <= 1'b1;
      if (fail_cnt != '1) fail_cnt <= fail_cnt + 1'b1;
    end
  end

  // once raised, the flag stays until the next run starts
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (fail && !clr) |=> fail);

  // a nonzero count always comes with the flag
  p_count_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (fail_cnt != '0) |-> fail);

  // the count never falls within a run
  p_count_mono_r10: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (fail_cnt >= $past(fail_cnt)));

endmodule

// File: rtl/scan_test_sequencer.sv
module scan_test_sequencer #(
  parameter int CHAIN_LEN = 4,
  parameter int NUM_VEC   = 4,
  parameter int PI_W      = 4,
  parameter int PO_W      = 4,
  parameter int FAIL_W    = 8,
  parameter int CYC_W     = 16,
  parameter int VEC_AW    = $clog2(NUM_VEC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 vec_we,
  input  logic [VEC_AW-1:0]    vec_addr,
  input  logic [CHAIN_LEN-1:0] vec_state,
  input  logic [PI_W-1:0]      vec_pi,
  input  logic [PO_W-1:0]      vec_exp_po,
  input  logic [CHAIN_LEN-1:0] vec_exp_ns,
  output logic                 scan_tc,
  output logic                 scan_si,
  output logic [PI_W-1:0]      scan_pi,
  input  logic                 scan_so,
  input  logic [PO_W-1:0]      po_obs,
  output logic                 busy,
  output logic                 done,
  output logic                 fail,
  output logic [FAIL_W-1:0]    fail_cnt,
  output logic [CYC_W-1:0]     cycle_cnt
);

  localparam int REC_W = 2*CHAIN_LEN + PI_W + PO_W;

  logic [REC_W-1:0]  wr_rec, rd_rec;
  logic [VEC_AW-1:0] rd_addr;
  logic              run_clr, so_chk_en, so_exp, po_chk_en;
  logic [PO_W-1:0]   po_exp;

  // record layout, low to high: expected next state, expected outputs, inputs, state
  assign wr_rec = {vec_state, vec_pi, vec_exp_po, vec_exp_ns};

  scan_vec_store #(
    .DEPTH (NUM_VEC),
    .AW    (VEC_AW),
    .W     (REC_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (vec_we && !busy),
    .wr_addr (vec_addr),
    .wr_data (wr_rec),
    .rd_addr (rd_addr),
    .rd_data (rd_rec)
  );

  scan_seq_ctrl #(
    .N     (CHAIN_LEN),
    .NV    (NUM_VEC),
    .PI_W  (PI_W),
    .PO_W  (PO_W),
    .VAW   (VEC_AW),
    .CYC_W (CYC_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rd_data   (rd_rec),
    .rd_addr   (rd_addr),
    .scan_tc   (scan_tc),
    .scan_si   (scan_si),
    .scan_pi   (scan_pi),
    .busy      (busy),
    .done      (done),
    .cycle_cnt (cycle_cnt),
    .run_clr   (run_clr),
    .so_chk_en (so_chk_en),
    .so_exp    (so_exp),
    .po_chk_en (po_chk_en),
    .po_exp    (po_exp)
  );

  scan_resp_check #(
    .PO_W   (PO_W),
    .FAIL_W (FAIL_W)
  ) u_check (
    .clk      (clk),
    .rst      (rst),
    .clr      (run_clr),
    .so_en    (so_chk_en),
    .so_exp   (so_exp),
    .so_obs   (scan_so),
    .po_en    (po_chk_en),
    .po_exp   (po_exp),
    .po_obs   (po_obs),
    .fail     (fail),
    .fail_cnt (fail_cnt)
  );

endmodule

// File: tb/scan_test_sequencer_test.sv
module scan_test_sequencer_test;

  localparam int N  = 4;
  localparam int NV = 4;
  localparam int TOTAL = (NV + 2) * N + NV + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic vec_we = 1'b0;
  logic [1:0] vec_addr = '0;
  logic [3:0] vec_state = '0, vec_pi = '0, vec_exp_po = '0, vec_exp_ns = '0;
  logic scan_tc, scan_si, scan_so, busy, done, fail;
  logic [3:0] scan_pi, po_obs;
  logic [7:0] fail_cnt;
  logic [15:0] cycle_cnt;

  always #5 clk = ~clk;

  scan_test_sequencer uut (
    .clk(clk), .rst(rst), .start(start), .vec_we(vec_we), .vec_addr(vec_addr),
    .vec_state(vec_state), .vec_pi(vec_pi), .vec_exp_po(vec_exp_po), .vec_exp_ns(vec_exp_ns),
    .scan_tc(scan_tc), .scan_si(scan_si), .scan_pi(scan_pi), .scan_so(scan_so),
    .po_obs(po_obs), .busy(busy), .done(done), .fail(fail), .fail_cnt(fail_cnt),
    .cycle_cnt(cycle_cnt)
  );

  // logic under test: four-stage mux-D chain plus combinational functions
  function automatic logic [3:0] ns_fn(input logic [3:0] s, input logic [3:0] p);
    return s + p + 4'd1;
  endfunction
  function automatic logic [3:0] po_fn(input logic [3:0] s, input logic [3:0] p);
    return s ^ {p[0], p[3:1]};
  endfunction

  logic [3:0] chain = '0;
  logic       stuck = 1'b0;
  logic [3:0] chain_eff;
  assign chain_eff = stuck ? (chain & 4'b1101) : chain;
  assign scan_so   = chain_eff[3];
  assign po_obs    = po_fn(chain_eff, scan_pi);

  always @(posedge clk) begin
    if (scan_tc) chain <= ns_fn(chain_eff, scan_pi);
    else         chain <= {chain_eff[2:0], scan_si};
  end

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [3:0] pi_a [NV];

  // monitor of the drive side, sampled at falling edges
  int idx, caps, flush_err, cap_err, pi_err, unload_err, done_cnt;
  int done_cyc, done_fail, done_fcnt, done_busy;

  always @(negedge clk) begin
    if (busy) begin
      if (idx < N + 4) begin
        if (scan_tc || (scan_si != idx[1])) flush_err++;
      end
      if (scan_tc) begin
        if (idx != 2*N + 4 + caps*(N + 1)) cap_err++;
        if (caps < NV && scan_pi != pi_a[caps]) pi_err++;
        caps++;
      end else begin
        if (scan_pi != 4'd0) pi_err++;
        if (caps == NV && scan_si) unload_err++;
      end
      idx++;
    end
    if (done) begin
      done_cnt++;
      done_cyc  = int'(cycle_cnt);
      done_fail = int'(fail);
      done_fcnt = int'(fail_cnt);
      done_busy = int'(busy);
    end
  end

  task automatic load_vecs(input int seed, input int po_bad, input logic [3:0] po_mask,
                           input int ns_bad, input logic [3:0] ns_mask);
    for (int k = 0; k < NV; k++) begin
      logic [3:0] st, pv;
      st = 4'(seed * 3 + k * 5 + 1);
      pv = 4'(seed + k * 7 + 2);
      pi_a[k] = pv;
      @(negedge clk);
      vec_we     = 1'b1;
      vec_addr   = 2'(k);
      vec_state  = st;
      vec_pi     = pv;
      vec_exp_po = po_fn(st, pv) ^ ((k == po_bad) ? po_mask : 4'd0);
      vec_exp_ns = ns_fn(st, pv) ^ ((k == ns_bad) ? ns_mask : 4'd0);
    end
    @(negedge clk);
    vec_we = 1'b0;
  endtask

  task automatic run_seq(input bit extra_start);
    int n;
    idx = 0; caps = 0; flush_err = 0; cap_err = 0; pi_err = 0; unload_err = 0;
    done_cnt = 0; done_cyc = -1; done_fail = -1; done_fcnt = -1; done_busy = -1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (done_cnt == 0 && n < 1000) begin
      @(negedge clk);
      start = (extra_start && n == 10);
      n++;
    end
    start = 1'b0;
    if (n >= 1000) check(1'b0, "watchdog", n, TOTAL);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(scan_tc == 0 && scan_si == 0 && scan_pi == 0, "R1 drive", int'(scan_pi), 0);
    check(busy == 0 && done == 0 && fail == 0, "R1 flags", int'(busy | done | fail), 0);
    check(fail_cnt == 0 && cycle_cnt == 0, "R1 counts", int'(cycle_cnt), 0);
    rst = 1'b0;

    // clean run
    load_vecs(0, -1, 4'd0, -1, 4'd0);
    run_seq(1'b0);
    check(flush_err == 0, "R2 flush pattern", flush_err, 0);
    check(caps == NV && pi_err == 0, "R4 captures", caps, NV);
    check(cap_err == 0, "R5 capture spacing", cap_err, 0);
    check(unload_err == 0, "R6 unload fill", unload_err, 0);
    check(done_cyc == TOTAL, "R7 cycle count", done_cyc, TOTAL);
    check(done_fail == 0 && done_fcnt == 0, "R8 clean run", done_fcnt, 0);
    check(done_cnt == 1 && done_busy == 0, "R11 done pulse", done_cnt, 1);

    // clean run with other data and a start pulse while busy
    load_vecs(5, -1, 4'd0, -1, 4'd0);
    run_seq(1'b1);
    check(done_cyc == TOTAL && done_cnt == 1, "R12 start ignored", done_cyc, TOTAL);
    check(done_fail == 0 && caps == NV, "R12 run intact", done_fcnt, 0);
    check(pi_err == 0 && cap_err == 0, "R4 second data set", pi_err + cap_err, 0);

    // one primary-output mismatch
    load_vecs(2, 1, 4'b1000, -1, 4'd0);
    run_seq(1'b0);
    check(done_fail == 1 && done_fcnt == 1, "R9 output mismatch", done_fcnt, 1);

    // two next-state bits wrong in a middle vector
    load_vecs(3, -1, 4'd0, 2, 4'b0101);
    run_seq(1'b0);
    check(done_fail == 1 && done_fcnt == 2, "R10 overlapped unload", done_fcnt, 2);

    // one next-state bit wrong in the last vector: seen in final unload
    load_vecs(7, -1, 4'd0, 3, 4'b0001);
    run_seq(1'b0);
    check(done_fail == 1 && done_fcnt == 1, "R10 final unload", done_fcnt, 1);

    // chain defect: stage 1 stuck at 0
    stuck = 1'b1;
    load_vecs(1, -1, 4'd0, -1, 4'd0);
    run_seq(1'b0);
    check(done_fail == 1 && done_fcnt >= 2, "R3 chain defect", done_fcnt, 2);
    stuck = 1'b0;

    // clean again: the flags from the failing run are cleared
    load_vecs(4, -1, 4'd0, -1, 4'd0);
    run_seq(1'b0);
    check(done_fail == 0 && done_fcnt == 0, "R8 cleared on start", done_fcnt, 0);
    check(fail == 0 && busy == 0 && done == 0, "R11 idle after run", int'(fail), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule